// File: doc/BRIEF.md
# USB Charger-Type Detection Controller

This controller decides what kind of power source sits on the far end of a USB receptacle. It is a sequential state machine. Its inputs are already-digitized comparator results: bus voltage valid, data-line contact, data-line short, a charging-port probe response, and coarse bands that place each data-line voltage against fixed fractions of VBUS. Its outputs are enables for the probe sources, a control that keeps the data switch open while probing, a 3-bit charger-type code, and three charger-enable lines for an external battery charger.

One run checks data contact first, with a timeout and a bypass for a contact test that gets stuck. A timed dead-battery phase follows when the battery is weak. The controller then looks for proprietary divider chargers, then tests for a shorted D+/D- pair, and last probes for a charging downstream port. All timing comes from a 1 ms tick input, so the block can run on any clock. Software controls are plain level pins, except for two single-cycle request pulses. No data streams through the block, so there is no valid/ready handshake.

Top module: `chgdet_ctrl`

## Requirements
- R1: When `vbus_ok` has stayed high for DEB_MS ticks and either `det_en` or `man_pend` is 1, a run starts: `running` and `dcd_src_en` go to 1. While `det_en` and `man_pend` are both 0, valid VBUS starts nothing.
- R2: In any state, `vbus_ok` at 0 returns the controller to dormant. On the next cycle `running` is 0 and `chg_code` is 000.
- R3: A test step decides only after the input it watches has kept one value for DEB_MS ticks. Any change of that input restarts the count. In the contact test the input must also be 1.
- R4: While a run is in progress `sw_close` is 0. At all other times it equals `sw_req`, so when a run ends the switch goes back to the state that software requested.
- R5: When no contact has been accepted after DCD_MS ticks in the contact test, `dcd_to` becomes 1 and stays 1 until the next run starts. With `to_exit`=1 the controller then leaves the contact test. With `dcd_en`=0 the contact test is skipped or left at once.
- R6: The charging-port probe keeps `dp_src_en` high for at least SRC_SHORT_MS ticks (`long_src`=0) or SRC_LONG_MS ticks (`long_src`=1). After that time, and once `port_resp` has been debounced, the result is 010 (charging port) when `port_resp`=1 and 001 (standard port) when it is 0.
- R7: When the debounced `short_det` is 1 in the short test, the result is 011 (dedicated charger) and the probe phase is skipped.
- R8: The band codes of `dp_band`/`dm_band` are 0 for below 26 % of VBUS, 1 for 26–47 %, 2 for 47–60 % and 3 for above 60 %. D+ in band 1 with D- in band 1 gives 100 (special, 0.5 A). D+ in band 1 with D- in band 2 gives 101 (special, 1 A). Any other pair continues to the short test.
- R9: When `weak_bat` is 1 as the contact test ends, the controller enters dead-battery mode: `db_active`=1 and `chg_code`=111. The mode ends after DB_MS ticks or on a `db_exit` pulse. The code stays 111, so charging stays enabled, until the run's final result replaces it.
- R10: `ce` = {ce2,ce1,ce0} follows this policy. The disabled pattern is {~sus_pol,~sus_pol,1}. Codes 000 and 110, and code 001 with `usb_cpl`=1, give the disabled pattern. Code 001 with `usb_cpl`=0 and code 100 give 100. Codes 010, 011 and 101 give 010. Code 111 gives 000.
- R11: When `ce_force`=1, `ce` equals `ce_sw`, and detection results have no effect on it.
- R12: A `man_req` pulse sets `man_pend`. From the done state this starts a new run at once. `man_pend` clears when a run reaches its result.
- R13: `running` is 1 exactly during the contact, dead-battery, divider, short and probe steps. Timers and debounce counts advance only on cycles with `tick_ms`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| vbus_ok | input | 1 | VBUS above detect threshold |
| det_en | input | 1 | Automatic detection on VBUS enabled |
| man_req | input | 1 | Pulse: request a manual detection |
| dcd_en | input | 1 | Data contact test enabled |
| to_exit | input | 1 | Leave contact test on timeout |
| long_src | input | 1 | Select long probe source time |
| weak_bat | input | 1 | Battery below weak threshold |
| db_exit | input | 1 | Pulse: leave dead-battery mode |
| dcd_contact | input | 1 | Data contact seen |
| dp_band | input | 2 | D+ voltage band vs. VBUS |
| dm_band | input | 2 | D- voltage band vs. VBUS |
| short_det | input | 1 | D+/D- short seen |
| port_resp | input | 1 | Charging-port probe response |
| sw_req | input | 1 | Software data-switch setting |
| usb_cpl | input | 1 | Device follows USB current rules |
| sus_pol | input | 1 | Polarity of the disabled enable pattern |
| ce_force | input | 1 | Override charger enables |
| ce_sw | input | 3 | Software charger-enable value |
| dcd_src_en | output | 1 | Contact-test source enable |
| dp_src_en | output | 1 | Probe source enable |
| sw_close | output | 1 | Data switch closed |
| running | output | 1 | Detection in progress |
| db_active | output | 1 | Dead-battery mode active |
| dcd_to | output | 1 | Contact test timed out |
| man_pend | output | 1 | Manual detection pending |
| chg_code | output | 3 | Charger-type code |
| ce | output | 3 | Charger enables {ce2,ce1,ce0} |

## Verification
The assertions take for granted that every comparator input is already synchronized to `clk`, that `tick_ms`, `man_req` and `db_exit` are single-cycle pulses, and that nothing changes `vbus_ok` except a real attach or detach. The bench changes inputs only on the falling clock edge. It holds band, short and response inputs fixed for a whole run, except where the debounce restart is being exercised on purpose. Timing checks use windows a few cycles wide around the tick counts in the requirements.

// File: rtl/chgdet_pkg.sv
`timescale 1ns/1ps
package chgdet_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DCD   = 3'd1,
    ST_DBAT  = 3'd2,
    ST_DIV   = 3'd3,
    ST_SHORT = 3'd4,
    ST_PROBE = 3'd5,
    ST_DONE  = 3'd6
  } det_st_e;

  localparam logic [2:0] CT_NONE   = 3'b000;
  localparam logic [2:0] CT_SDP    = 3'b001;
  localparam logic [2:0] CT_CDP    = 3'b010;
  localparam logic [2:0] CT_DCP    = 3'b011;
  localparam logic [2:0] CT_SPC_LO = 3'b100;
  localparam logic [2:0] CT_SPC_HI = 3'b101;
  localparam logic [2:0] CT_DEAD   = 3'b111;

  // Charger-enable policy, result is {ce2, ce1, ce0}
  function automatic logic [2:0] ce_policy(input logic [2:0] code,
                                           input logic cpl,
                                           input logic sus);
    logic [2:0] off;
    off = {~sus, ~sus, 1'b1};
    case (code)
      CT_SDP:                    ce_policy = cpl ? off : 3'b100;
      CT_CDP, CT_DCP, CT_SPC_HI: ce_policy = 3'b010;
      CT_SPC_LO:                 ce_policy = 3'b100;
      CT_DEAD:                   ce_policy = 3'b000;
      default:                   ce_policy = off;
    endcase
  endfunction

endpackage

// File: rtl/chgdet_timer.sv
`timescale 1ns/1ps
module chgdet_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (tick && cnt != '1)  cnt <= cnt + 1'b1;
  end

  // R13: time only moves on a tick
  p_tmr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/chgdet_deb.sv
`timescale 1ns/1ps
module chgdet_deb #(
  parameter int W      = 4,
  parameter int DEB_MS = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] val,
  output logic         done
);

  localparam int CW = $clog2(DEB_MS + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_MS);

  logic [W-1:0]  prev;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      cnt  <= '0;
    end else begin
      prev <= val;
      if (clr || val != prev)     cnt <= '0;
      else if (tick && cnt < LIM) cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt >= LIM);

  // R3: any change of the watched value withdraws a pending decision
  p_deb_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (val != $past(val)) |=> !done);

  p_deb_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

endmodule

// File: rtl/chgdet_ce.sv
`timescale 1ns/1ps
module chgdet_ce
  import chgdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  input  logic       cpl,
  input  logic       sus,
  input  logic       force_en,
  input  logic [2:0] sw_val,
  output logic [2:0] ce
);

  logic [2:0] pol;

  always_comb pol = ce_policy(code, cpl, sus);

  assign ce = force_en ? sw_val : pol;

  // R11: under override the outputs move only with the software value
  p_force_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && $past(force_en) && $stable(sw_val)) |-> $stable(ce));

endmodule

// File: rtl/chgdet_ctrl.sv
`timescale 1ns/1ps
module chgdet_ctrl
  import chgdet_pkg::*;
#(
  parameter int DEB_MS       = 30,
  parameter int DCD_MS       = 2000,
  parameter int SRC_SHORT_MS = 40,
  parameter int SRC_LONG_MS  = 625,
  parameter int DB_MS        = 2700000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       vbus_ok,
  input  logic       det_en,
  input  logic       man_req,
  input  logic       dcd_en,
  input  logic       to_exit,
  input  logic       long_src,
  input  logic       weak_bat,
  input  logic       db_exit,
  input  logic       dcd_contact,
  input  logic [1:0] dp_band,
  input  logic [1:0] dm_band,
  input  logic       short_det,
  input  logic       port_resp,
  input  logic       sw_req,
  input  logic       usb_cpl,
  input  logic       sus_pol,
  input  logic       ce_force,
  input  logic [2:0] ce_sw,
  output logic       dcd_src_en,
  output logic       dp_src_en,
  output logic       sw_close,
  output logic       running,
  output logic       db_active,
  output logic       dcd_to,
  output logic       man_pend,
  output logic [2:0] chg_code,
  output logic [2:0] ce
);

  localparam int M1      = (DB_MS > DCD_MS) ? DB_MS : DCD_MS;
  localparam int LIM_MAX = (M1 > SRC_LONG_MS) ? M1 : SRC_LONG_MS;
  localparam int TW      = $clog2(LIM_MAX + 1);
  localparam logic [TW-1:0] T_DCD = TW'(DCD_MS);
  localparam logic [TW-1:0] T_DB  = TW'(DB_MS);
  localparam logic [TW-1:0] T_SS  = TW'(SRC_SHORT_MS);
  localparam logic [TW-1:0] T_SL  = TW'(SRC_LONG_MS);

  det_st_e       st, st_n;
  logic          entry;
  logic [TW-1:0] tmr;
  logic [3:0]    deb_val;
  logic          deb_ok;
  logic [2:0]    div_code, fin_code;
  logic [TW-1:0] src_lim;
  logic          contact_ok;

  assign entry = (st_n != st);

  chgdet_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(entry), .tick(tick_ms), .cnt(tmr)
  );

  // watched comparator per step
  always_comb begin
    case (st)
      ST_IDLE:  deb_val = {3'b000, vbus_ok};
      ST_DCD:   deb_val = {3'b000, dcd_contact};
      ST_DIV:   deb_val = {dp_band, dm_band};
      ST_SHORT: deb_val = {3'b000, short_det};
      ST_PROBE: deb_val = {3'b000, port_resp};
      default:  deb_val = 4'b0000;
    endcase
  end

  chgdet_deb #(.W(4), .DEB_MS(DEB_MS)) u_deb (
    .clk(clk), .rst_n(rst_n), .clr(entry), .tick(tick_ms),
    .val(deb_val), .done(deb_ok)
  );

  // divider classification
  always_comb begin
    div_code = CT_NONE;
    if (dp_band == 2'd1) begin
      if (dm_band == 2'd1)      div_code = CT_SPC_LO;
      else if (dm_band == 2'd2) div_code = CT_SPC_HI;
    end
  end

  always_comb begin
    case (st)
      ST_DIV:   fin_code = div_code;
      ST_SHORT: fin_code = CT_DCP;
      default:  fin_code = port_resp ? CT_CDP : CT_SDP;
    endcase
  end

  assign src_lim    = long_src ? T_SL : T_SS;
  assign contact_ok = dcd_contact && deb_ok;

  always_comb begin
    st_n = st;
    if (st != ST_IDLE && !vbus_ok) begin
      st_n = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:  if (vbus_ok && deb_ok && (det_en || man_pend)) st_n = ST_DCD;
        ST_DCD:   if (!dcd_en || contact_ok || (to_exit && tmr >= T_DCD))
                    st_n = weak_bat ? ST_DBAT : ST_DIV;
        ST_DBAT:  if (db_exit || tmr >= T_DB) st_n = ST_DIV;
        ST_DIV:   if (deb_ok) st_n = (div_code != CT_NONE) ? ST_DONE : ST_SHORT;
        ST_SHORT: if (deb_ok) st_n = short_det ? ST_DONE : ST_PROBE;
        ST_PROBE: if (deb_ok && tmr >= src_lim) st_n = ST_DONE;
        ST_DONE:  if (man_req || man_pend) st_n = ST_DCD;
        default:  st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      chg_code <= CT_NONE;
      dcd_to   <= 1'b0;
      man_pend <= 1'b0;
    end else begin
      st <= st_n;
      if (entry) begin
        case (st_n)
          ST_IDLE, ST_DCD: chg_code <= CT_NONE;
          ST_DBAT:         chg_code <= CT_DEAD;
          ST_DONE:         chg_code <= fin_code;
          default:         chg_code <= chg_code;
        endcase
      end
      if (entry && st_n == ST_DCD)              dcd_to <= 1'b0;
      else if (st == ST_DCD && tmr >= T_DCD)    dcd_to <= 1'b1;
      if (man_req)                              man_pend <= 1'b1;
      else if (entry && st_n == ST_DONE)        man_pend <= 1'b0;
    end
  end

  assign running    = (st == ST_DCD) || (st == ST_DBAT) || (st == ST_DIV) ||
                      (st == ST_SHORT) || (st == ST_PROBE);
  assign dcd_src_en = (st == ST_DCD);
  assign dp_src_en  = (st == ST_PROBE);
  assign db_active  = (st == ST_DBAT);
  assign sw_close   = sw_req && !running;

  chgdet_ce u_ce (
    .clk(clk), .rst_n(rst_n), .code(chg_code), .cpl(usb_cpl), .sus(sus_pol),
    .force_en(ce_force), .sw_val(ce_sw), .ce(ce)
  );

  // R2: loss of VBUS always lands in dormant with an empty result
  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_ok |=> (chg_code == CT_NONE && !running));

  // R4: a probe source never coexists with a closed data switch
  p_sw_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_src_en || dp_src_en) |-> !sw_close);

  p_src_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dcd_src_en, dp_src_en, db_active}));

  // R9: dead-battery mode reports its own code
  p_db_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    db_active |-> chg_code == CT_DEAD);

  // R5: the timeout flag only rises out of the contact test
  p_dcdto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dcd_to) |-> $past(st == ST_DCD));

  // R12: reaching a result drops the manual request
  p_man_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st == ST_DONE) && !$past(man_req)) |-> !man_pend);

endmodule

// File: tb/chgdet_ctrl_bench.sv
`timescale 1ns/1ps
module chgdet_ctrl_bench;

  localparam int DEB = 30;
  localparam int DBT = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b1, vbus_ok = 1'b0, det_en = 1'b0, man_req = 1'b0;
  logic dcd_en = 1'b1, to_exit = 1'b0, long_src = 1'b0, weak_bat = 1'b0;
  logic db_exit = 1'b0, dcd_contact = 1'b1, short_det = 1'b0, port_resp = 1'b0;
  logic [1:0] dp_band = 2'd0, dm_band = 2'd0;
  logic sw_req = 1'b0, usb_cpl = 1'b0, sus_pol = 1'b0, ce_force = 1'b0;
  logic [2:0] ce_sw = 3'b000;
  logic dcd_src_en, dp_src_en, sw_close, running, db_active, dcd_to, man_pend;
  logic [2:0] chg_code, ce;

  int errors = 0;
  int checks = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  chgdet_ctrl #(.DB_MS(DBT)) u_chgdet_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .vbus_ok(vbus_ok),
    .det_en(det_en), .man_req(man_req), .dcd_en(dcd_en), .to_exit(to_exit),
    .long_src(long_src), .weak_bat(weak_bat), .db_exit(db_exit),
    .dcd_contact(dcd_contact), .dp_band(dp_band), .dm_band(dm_band),
    .short_det(short_det), .port_resp(port_resp), .sw_req(sw_req),
    .usb_cpl(usb_cpl), .sus_pol(sus_pol), .ce_force(ce_force), .ce_sw(ce_sw),
    .dcd_src_en(dcd_src_en), .dp_src_en(dp_src_en), .sw_close(sw_close),
    .running(running), .db_active(db_active), .dcd_to(dcd_to),
    .man_pend(man_pend), .chg_code(chg_code), .ce(ce)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input logic [1:0] dp, input logic [1:0] dm,
                                          input logic sh, input logic rs);
    if (dp == 2'd1 && dm == 2'd1) return 3'b100;
    if (dp == 2'd1 && dm == 2'd2) return 3'b101;
    if (sh) return 3'b011;
    return rs ? 3'b010 : 3'b001;
  endfunction

  function automatic logic [2:0] exp_ce(input logic [2:0] c, input logic cpl, input logic sus);
    logic [2:0] dis;
    dis = {~sus, ~sus, 1'b1};
    case (c)
      3'b001: return cpl ? dis : 3'b100;
      3'b100: return 3'b100;
      3'b010, 3'b011, 3'b101: return 3'b010;
      3'b111: return 3'b000;
      default: return dis;
    endcase
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart();
    vbus_ok = 1'b0;
    cyc(3);
    vbus_ok = 1'b1;
  endtask

  // waits for a run to begin and end; returns cycles of probe source
  task automatic run_done(output int pn);
    int g;
    pn = 0;
    g = 0;
    while (!running && g < 3000) begin @(negedge clk); g++; end
    while (running && g < 6000) begin @(negedge clk); g++; if (dp_src_en) pn++; end
    if (g >= 6000) chk(1'b0, "RUN_END", g, 0);
  endtask

  task automatic wait_for_run(output int n);
    n = 0;
    while (!running && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int n, pn;
    logic [2:0] ec;
    void'($urandom(32'd4711));
    cyc(5);
    rst_n = 1'b1;
    cyc(1);

    // reset state
    chk(chg_code == 3'b000, "R2 reset code", chg_code, 0);
    chk(!running, "R13 reset running", running, 0);
    chk(ce == 3'b111, "R10 reset ce", ce, 7);
    chk(!sw_close, "R4 reset switch", sw_close, 0);
    sw_req = 1'b1;
    cyc(1);
    chk(sw_close, "R4 idle follows sw_req", sw_close, 1);

    // R1: no start without enable
    vbus_ok = 1'b1;
    cyc(100);
    chk(!running, "R1 no enable", running, 0);

    // R1: start after VBUS debounce
    vbus_ok = 1'b0;
    cyc(3);
    det_en = 1'b1;
    vbus_ok = 1'b1;
    wait_for_run(n);
    chk(n >= DEB && n <= DEB + 4, "R1 start delay", n, DEB + 2);
    chk(dcd_src_en, "R1 contact source", dcd_src_en, 1);
    chk(!sw_close, "R4 open during run", sw_close, 1'b0);
    run_done(pn);
    chk(chg_code == 3'b001, "R6 standard port", chg_code, 1);
    chk(pn >= 40 && pn <= 45, "R6 short source time", pn, 41);
    chk(sw_close, "R4 restored after run", sw_close, 1);

    // R6: long source, charging port
    long_src = 1'b1;
    port_resp = 1'b1;
    restart();
    run_done(pn);
    chk(chg_code == 3'b010, "R6 charging port", chg_code, 2);
    chk(pn >= 625 && pn <= 630, "R6 long source time", pn, 626);
    long_src = 1'b0;
    port_resp = 1'b0;

    // R7: short detected, probe skipped
    short_det = 1'b1;
    restart();
    run_done(pn);
    chk(chg_code == 3'b011, "R7 dedicated", chg_code, 3);
    chk(pn == 0, "R7 no probe", pn, 0);
    short_det = 1'b0;

    // R8: divider classes
    dp_band = 2'd1; dm_band = 2'd1;
    restart(); run_done(pn);
    chk(chg_code == 3'b100, "R8 special 0.5A", chg_code, 4);
    dm_band = 2'd2;
    restart(); run_done(pn);
    chk(chg_code == 3'b101, "R8 special 1A", chg_code, 5);
    dp_band = 2'd2;
    restart(); run_done(pn);
    chk(chg_code == 3'b001, "R8 non-special pair", chg_code, 1);
    dp_band = 2'd0; dm_band = 2'd0;

    // R3: toggling contact keeps contact test pending
    dcd_contact = 1'b0;
    restart();
    wait_for_run(n);
    for (int k = 0; k < 10; k++) begin
      dcd_contact = ~dcd_contact;
      cyc(20);
    end
    chk(dcd_src_en, "R3 bouncing contact held", dcd_src_en, 1);
    dcd_contact = 1'b1;
    n = 0;
    while (dcd_src_en && n < 200) begin @(negedge clk); n++; end
    chk(n >= DEB && n <= DEB + 4, "R3 stable contact delay", n, DEB + 2);
    run_done(pn);

    // R13: no tick, no progress
    dcd_contact = 1'b0;
    restart();
    wait_for_run(n);
    tick_ms = 1'b0;
    dcd_contact = 1'b1;
    cyc(100);
    chk(dcd_src_en, "R13 frozen without tick", dcd_src_en, 1);
    tick_ms = 1'b1;
    n = 0;
    while (dcd_src_en && n < 200) begin @(negedge clk); n++; end
    chk(n <= DEB + 4, "R13 resumes with tick", n, DEB + 2);
    run_done(pn);

    // R5: timeout flag, then dcd_en bypass
    dcd_contact = 1'b0;
    restart();
    wait_for_run(n);
    cyc(2010);
    chk(dcd_to, "R5 timeout flag", dcd_to, 1);
    chk(dcd_src_en, "R5 waits without exit", dcd_src_en, 1);
    dcd_en = 1'b0;
    cyc(2);
    chk(!dcd_src_en, "R5 bypass leaves test", dcd_src_en, 0);
    dcd_en = 1'b1;
    run_done(pn);
    chk(dcd_to, "R5 flag held", dcd_to, 1);

    // R5: exit on timeout
    to_exit = 1'b1;
    restart();
    wait_for_run(n);
    chk(!dcd_to, "R5 flag cleared at start", dcd_to, 0);
    n = 0;
    while (dcd_src_en && n < 3000) begin @(negedge clk); n++; end
    chk(n >= 2000 && n <= 2004, "R5 exit time", n, 2001);
    run_done(pn);
    to_exit = 1'b0;
    dcd_contact = 1'b1;

    // R2: abort mid probe
    long_src = 1'b1;
    restart();
    n = 0;
    while (!dp_src_en && n < 2000) begin @(negedge clk); n++; end
    vbus_ok = 1'b0;
    cyc(1);
    chk(!running, "R2 abort running", running, 0);
    chk(chg_code == 3'b000, "R2 abort code", chg_code, 0);
    long_src = 1'b0;

    // R9: dead battery with exit request
    weak_bat = 1'b1;
    restart();
    n = 0;
    while (!db_active && n < 2000) begin @(negedge clk); n++; end
    chk(chg_code == 3'b111, "R9 dead code", chg_code, 7);
    chk(ce == 3'b000, "R9 dead enables", ce, 0);
    cyc(10);
    db_exit = 1'b1;
    cyc(1);
    db_exit = 1'b0;
    cyc(1);
    chk(!db_active, "R9 exit request", db_active, 0);
    chk(chg_code == 3'b111 && running, "R9 charging kept", chg_code, 7);
    run_done(pn);
    chk(chg_code == 3'b001, "R9 result after exit", chg_code, 1);

    // R9: dead battery timeout
    restart();
    n = 0;
    while (!db_active && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    while (db_active && n < 2000) begin @(negedge clk); n++; end
    chk(n >= DBT && n <= DBT + 3, "R9 timeout length", n, DBT + 1);
    run_done(pn);
    weak_bat = 1'b0;

    // R12: manual request from done
    det_en = 1'b0;
    man_req = 1'b1;
    cyc(1);
    man_req = 1'b0;
    chk(man_pend, "R12 pending set", man_pend, 1);
    chk(running, "R12 immediate start", running, 1);
    run_done(pn);
    chk(!man_pend, "R12 pending cleared", man_pend, 0);
    // R12: manual from dormant
    vbus_ok = 1'b0;
    cyc(3);
    vbus_ok = 1'b1;
    man_req = 1'b1;
    cyc(1);
    man_req = 1'b0;
    wait_for_run(n);
    chk(running, "R12 start from dormant", running, 1);
    run_done(pn);
    chk(!man_pend && chg_code == 3'b001, "R12 manual result", chg_code, 1);
    det_en = 1'b1;

    // R11: forced enables ignore detection
    ce_force = 1'b1;
    ce_sw = 3'b101;
    cyc(1);
    chk(ce == 3'b101, "R11 forced value", ce, 5);
    short_det = 1'b1;
    restart();
    run_done(pn);
    chk(ce == 3'b101, "R11 forced after new result", ce, 5);
    ce_force = 1'b0;
    short_det = 1'b0;

    // R10 and R6-R8: random scenarios against bench model
    for (int s = 0; s < 16; s++) begin
      dp_band   = 2'($urandom_range(0, 3));
      dm_band   = 2'($urandom_range(0, 3));
      short_det = 1'($urandom_range(0, 1));
      port_resp = 1'($urandom_range(0, 1));
      long_src  = 1'($urandom_range(0, 3) == 0);
      sw_req    = 1'($urandom_range(0, 1));
      restart();
      run_done(pn);
      ec = exp_code(dp_band, dm_band, short_det, port_resp);
      chk(chg_code == ec, "R8 random code", chg_code, ec);
      chk(sw_close == sw_req, "R4 random switch", sw_close, sw_req);
      for (int m = 0; m < 4; m++) begin
        usb_cpl = m[0];
        sus_pol = m[1];
        cyc(1);
        chk(ce == exp_ce(chg_code, usb_cpl, sus_pol), "R10 policy", ce,
            exp_ce(chg_code, usb_cpl, sus_pol));
      end
    end

    // R10: dormant code with both suspend polarities
    vbus_ok = 1'b0;
    usb_cpl = 1'b0;
    sus_pol = 1'b1;
    cyc(2);
    chk(ce == 3'b001, "R10 disabled low", ce, 1);
    sus_pol = 1'b0;
    cyc(1);
    chk(ce == 3'b111, "R10 disabled high", ce, 7);

    fin = 1'b1;
    summary();
    $finish;
  end

endmodule